// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 262,144 one-bit cells. The RAM has an 18-bit address, separate data-in and data-out pins, an active-low chip select and an active-low write strobe. The host issues single-beat requests on a valid/ready channel carrying an address, a write flag and one data bit. Reads come back as a one-cycle response pulse with the sampled bit. Every analog minimum (read cycle, write pulse, address-to-end-of-write, data setup, write cycle) is turned into a whole number of clock cycles from parameters. Each count is rounded up and is never less than one.

Writes are ended by the write strobe rising while chip select is still low. Address and data-in are registered when a request is taken, and they only change while both strobes are high. A low-voltage retention handshake parks the RAM deselected. Leaving it starts a recovery wait of one read cycle time before the host is served again. The same wait follows reset.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the request and its fields stable until that edge. `req_ready` is high only when no access, retention or recovery is in progress. The response channel has no back-pressure: the host must take `rsp_rdata` in the single cycle in which `rsp_valid` is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is high, both strobes are high and `req_ready`, `rsp_valid` and `ret_active` are low. After `rst` falls, `req_ready` rises after exactly RC clock edges, where RC = max(1, ceil(T_RC_NS / CLK_NS)). This is 9 with the defaults.
- R2: A read holds `sram_ce_n` low and `sram_we_n` high for RC cycles. `sram_q` is sampled on the last edge of that window. `rsp_valid` is high for exactly one cycle, starting RC edges after the accepting edge, and `rsp_rdata` then equals the bit last written to that address (0 if the address was never written).
- R3: A write runs in three phases with `sram_ce_n` low throughout: SU cycles with `sram_we_n` high, then PW cycles with `sram_we_n` low, then HD cycles with `sram_we_n` high. The write ends on the rising edge of `sram_we_n` while chip select is still low. `req_ready` returns SU+PW+HD edges after the accepting edge.
- R4: The phase lengths are computed as follows. PW = max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)). SU = max(1, AWC − PW), where AWC = ceil(T_AW_NS/CLK_NS). HD = max(1, WCC − SU − PW), where WCC = ceil(T_WC_NS/CLK_NS). Every low period of `sram_ce_n` lasts at least max(RC, WCC) cycles.
- R5: `sram_addr` and `sram_d` never change while `sram_ce_n` stays low.
- R6: `req_ready` is high only while the controller is idle, and only when `sram_ce_n` is high. A request presented while `req_ready` is low is not taken and causes no RAM access.
- R7: `sram_we_n` is never low while `sram_ce_n` is high. `rsp_valid` never pulses for a write, so the data-out pin is ignored during writes.
- R8: `ret_req` is acted on only in the idle state. `ret_active` rises one edge after it is sampled there, and `sram_ce_n` is high whenever `ret_active` is high. A `ret_req` pulse that arrives during an access is dropped.
- R9: `ret_exit` sampled while `ret_active` is high clears `ret_active` on that edge. `req_ready` then returns RC edges later, which is RC+1 edges counting the edge that sampled the exit. Requests presented during retention or recovery are not performed.
- R10: When `req_valid` and `ret_req` are both high in the idle state, the host access is taken and retention is not entered on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Cell address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 1 | Read bit, valid with rsp_valid |
| ret_req | input | 1 | Request to enter retention |
| ret_exit | input | 1 | Supply restored, leave retention |
| ret_active | output | 1 | RAM is deselected and may be lowered to retention voltage |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_addr | output | 18 | RAM address |
| sram_d | output | 1 | RAM data-in |
| sram_q | input | 1 | RAM data-out |

## Verification
The bench drives the controller against a behavioural RAM model. The model returns the inverted bit whenever the read window is shorter than the access time, so any truncated read shows up as wrong data rather than silent luck. Random mixes of reads and writes over a small address pool give frequent read-after-write hits and overwrites, which separate real storage from stale or misrouted data. Directed cases cover the end addresses, a host request colliding with a retention request, retention entered with requests pending, and a retention pulse during a busy write. Each of these distinguishes correct idle-only gating from a controller that reacts at the wrong time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RETAIN,
    ST_RECOVER
  } ctl_state_e;

  // Minimum time in ns -> whole clock cycles, rounded up, never below one.
  function automatic int unsigned cyc_of(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
// Down counter that defines how long each phase lasts.
module sram_cycle_timer #(
  parameter int unsigned W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= RST_VAL;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_access_fsm.sv
// Phase sequencer: boot wait, read window, three-phase write, retention, recovery.
module sram_access_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 9,
  parameter int unsigned SU_CYC = 3,
  parameter int unsigned PW_CYC = 5,
  parameter int unsigned HD_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic ret_req,
  input  logic ret_exit,
  output logic req_ready,
  output logic accept,
  output logic rd_last,
  output logic ce_n,
  output logic we_n,
  output logic ret_active
);

  localparam int unsigned MAXC = max2(max2(RD_CYC, SU_CYC), max2(PW_CYC, HD_CYC));
  localparam int unsigned TW   = ($clog2(MAXC) < 1) ? 1 : $clog2(MAXC);
  localparam logic [TW-1:0] RD_LD = TW'(RD_CYC - 1);
  localparam logic [TW-1:0] SU_LD = TW'(SU_CYC - 1);
  localparam logic [TW-1:0] PW_LD = TW'(PW_CYC - 1);
  localparam logic [TW-1:0] HD_LD = TW'(HD_CYC - 1);

  ctl_state_e    state, nxt;
  logic          load, done;
  logic [TW-1:0] load_val;

  sram_cycle_timer #(.W(TW), .RST_VAL(RD_LD)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_BOOT, ST_RECOVER: if (done) nxt = ST_IDLE;
      ST_IDLE: begin
        if (req_valid) begin
          load = 1'b1;
          if (req_write) begin
            nxt      = ST_WSETUP;
            load_val = SU_LD;
          end else begin
            nxt      = ST_READ;
            load_val = RD_LD;
          end
        end else if (ret_req) begin
          nxt = ST_RETAIN;
        end
      end
      ST_READ:   if (done) nxt = ST_IDLE;
      ST_WSETUP: if (done) begin nxt = ST_WPULSE; load = 1'b1; load_val = PW_LD; end
      ST_WPULSE: if (done) begin nxt = ST_WHOLD;  load = 1'b1; load_val = HD_LD; end
      ST_WHOLD:  if (done) nxt = ST_IDLE;
      ST_RETAIN: if (ret_exit) begin nxt = ST_RECOVER; load = 1'b1; load_val = RD_LD; end
      default:   nxt = ST_IDLE;
    endcase
  end

  // Strobes come straight from flops so the RAM pins never glitch.
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_BOOT;
      ce_n       <= 1'b1;
      we_n       <= 1'b1;
      ret_active <= 1'b0;
    end else begin
      state      <= nxt;
      ce_n       <= !(nxt == ST_READ || nxt == ST_WSETUP || nxt == ST_WPULSE || nxt == ST_WHOLD);
      we_n       <= !(nxt == ST_WPULSE);
      ret_active <= (nxt == ST_RETAIN);
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_last   = (state == ST_READ) && done;

endmodule

// File: rtl/sram_req_capture.sv
// Holds address and data-in for the whole access; captures the read bit.
module sram_req_capture #(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  input  logic          rd_last,
  input  logic          sram_q,
  output logic [AW-1:0] sram_addr,
  output logic          sram_d,
  output logic          rsp_valid,
  output logic          rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr <= '0;
      sram_d    <= 1'b0;
    end else if (accept) begin
      sram_addr <= req_addr;
      sram_d    <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= rd_last;
      if (rd_last) rsp_rdata <= sram_q;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned CLK_NS   = 4,
  parameter int unsigned T_RC_NS  = 35,
  parameter int unsigned T_WC_NS  = 35,
  parameter int unsigned T_WP_NS  = 20,
  parameter int unsigned T_AW_NS  = 30,
  parameter int unsigned T_DS_NS  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  input  logic              ret_req,
  input  logic              ret_exit,
  output logic              ret_active,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_d,
  input  logic              sram_q
);

  localparam int unsigned RC_CYC  = cyc_of(T_RC_NS, CLK_NS);
  localparam int unsigned WC_CYC  = cyc_of(T_WC_NS, CLK_NS);
  localparam int unsigned AW_CYC  = cyc_of(T_AW_NS, CLK_NS);
  localparam int unsigned PW_CYC  = max2(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_DS_NS, CLK_NS));
  localparam int unsigned SU_CYC  = (AW_CYC > PW_CYC) ? AW_CYC - PW_CYC : 1;
  localparam int unsigned HD_CYC  = (WC_CYC > SU_CYC + PW_CYC) ? WC_CYC - SU_CYC - PW_CYC : 1;

  logic accept, rd_last;

  sram_access_fsm #(
    .RD_CYC (RC_CYC),
    .SU_CYC (SU_CYC),
    .PW_CYC (PW_CYC),
    .HD_CYC (HD_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .ret_req    (ret_req),
    .ret_exit   (ret_exit),
    .req_ready  (req_ready),
    .accept     (accept),
    .rd_last    (rd_last),
    .ce_n       (sram_ce_n),
    .we_n       (sram_we_n),
    .ret_active (ret_active)
  );

  sram_req_capture #(.AW(ADDR_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_last   (rd_last),
    .sram_q    (sram_q),
    .sram_addr (sram_addr),
    .sram_d    (sram_d),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctrl_props.sv
module sram_ctrl_props #(
  parameter int unsigned AW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          ret_active,
  input logic          sram_ce_n,
  input logic          sram_we_n,
  input logic [AW-1:0] sram_addr,
  input logic          sram_d
);

  // R7: write strobe only inside a selected cycle
  p_we_inside_ce_r7: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n);

  // R7: no read response while the data-out pin is being ignored
  p_no_rsp_in_write_r7: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !rsp_valid);

  // R5: address and data-in frozen while selected
  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_d)));

  // R2: response is a single-cycle pulse
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6: ready only while deselected
  p_ready_deselected_r6: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> sram_ce_n);

  // R8: retention only with the chip deselected
  p_ret_deselected_r8: assert property (@(posedge clk) disable iff (rst)
    ret_active |-> (sram_ce_n && !req_ready));

  // R9: leaving retention goes into recovery, not straight to ready
  p_recover_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ret_active) |-> !req_ready);

endmodule

bind sram_async_ctrl sram_ctrl_props #(.AW(ADDR_W)) u_props (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ret_active (ret_active),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_addr  (sram_addr),
  .sram_d     (sram_d)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;

  localparam int unsigned AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          ret_req = 1'b0, ret_exit = 1'b0;
  logic          req_ready, rsp_valid, rsp_rdata, ret_active;
  logic          sram_ce_n, sram_we_n, sram_d;
  logic [AW-1:0] sram_addr;
  logic          sram_q = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
    .ret_exit(ret_exit), .ret_active(ret_active), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_addr(sram_addr), .sram_d(sram_d), .sram_q(sram_q)
  );

  // Expected cycle counts, derived from the requirement formulas.
  function automatic int ceil_cyc(input int t, input int p);
    int c;
    c = (t + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int rc, wcc, awc, pw, su, hd;
  initial begin
    rc  = ceil_cyc(35, 4);
    wcc = ceil_cyc(35, 4);
    awc = ceil_cyc(30, 4);
    pw  = imax(ceil_cyc(20, 4), ceil_cyc(20, 4));
    su  = (awc > pw) ? awc - pw : 1;
    hd  = (wcc > su + pw) ? wcc - su - pw : 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  bit          mem [int unsigned];
  bit          shadow [int unsigned];
  int          ce_run = 0, rd_age = 0, wp_age = 0;
  logic        last_we = 1'b1;
  logic [AW-1:0] last_addr = '0;
  logic        last_d = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      ce_run = 0; rd_age = 0; wp_age = 0;
    end else begin
      if (sram_we_n && !last_we) begin
        check(!sram_ce_n, "R3", "write ended by we rise with ce low", int'(sram_ce_n), 0);
        check(wp_age >= pw, "R4", "we low cycles", wp_age, pw);
        check(ce_run >= awc, "R4", "ce low before end of write", ce_run, awc);
        mem[int'(sram_addr)] = sram_d;
      end
      if (!sram_ce_n) begin
        if (ce_run > 0 && (sram_addr != last_addr || sram_d != last_d))
          check(1'b0, "R5", "addr/din moved while selected", int'(sram_addr), int'(last_addr));
        ce_run++;
        if (sram_we_n) rd_age++;
        else wp_age++;
      end else begin
        if (ce_run > 0)
          check(ce_run >= imax(rc, wcc), "R4", "ce low period", ce_run, imax(rc, wcc));
        if (!sram_we_n) check(1'b0, "R7", "we low while ce high", 0, 1);
        ce_run = 0; rd_age = 0; wp_age = 0;
      end
    end
    last_we   = sram_we_n;
    last_addr = sram_addr;
    last_d    = sram_d;
  end

  // Data-out: correct only once the access time has elapsed, inverted before.
  always @(negedge clk) begin
    bit v;
    v = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 1'b0;
    if (!sram_ce_n && sram_we_n && rd_age >= rc - 1) sram_q <= v;
    else sram_q <= ~v;
  end

  // ---------------- host tasks ----------------
  task automatic do_write(input logic [AW-1:0] a, input bit d);
    int lat;
    bit rv_seen;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    lat = 0; rv_seen = 0;
    while (!req_ready && lat < 100) begin
      if (rsp_valid) rv_seen = 1;
      @(posedge clk); @(negedge clk); lat++;
    end
    check(lat == su + pw + hd, "R3", "write busy edges", lat, su + pw + hd);
    check(!rv_seen, "R7", "rsp_valid during write", int'(rv_seen), 0);
    shadow[int'(a)] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int lat;
    bit exp, rdy_bad;
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    lat = 0; rdy_bad = 0;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) rdy_bad = 1;
      @(posedge clk); @(negedge clk); lat++;
    end
    check(lat == rc, "R2", "read response latency", lat, rc);
    check(!rdy_bad, "R6", "ready low during read", int'(rdy_bad), 0);
    check(rsp_rdata == exp, "R2", "read data", int'(rsp_rdata), int'(exp));
    @(posedge clk); @(negedge clk);
    check(!rsp_valid, "R2", "rsp_valid single cycle", int'(rsp_valid), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  // ---------------- main sequence ----------------
  logic [AW-1:0] pool [8];
  initial begin
    int lat;
    bit bad;
    int unsigned seed_sink;
    seed_sink = $urandom(32'h5EED);

    // R1: reset state
    repeat (4) @(negedge clk);
    check(sram_ce_n && sram_we_n, "R1", "strobes high in reset", int'({sram_ce_n, sram_we_n}), 3);
    check(!req_ready && !rsp_valid && !ret_active, "R1", "outputs low in reset",
          int'({req_ready, rsp_valid, ret_active}), 0);
    rst = 1'b0;
    lat = 0;
    while (!req_ready && lat < 100) begin @(posedge clk); @(negedge clk); lat++; end
    check(lat == rc, "R1", "boot wait edges", lat, rc);

    // Corner addresses, unwritten read gives 0
    do_read(18'h00000);
    do_write(18'h3FFFF, 1'b1);
    do_write(18'h00000, 1'b1);
    do_read(18'h3FFFF);
    do_read(18'h00000);
    do_write(18'h3FFFF, 1'b0);
    do_read(18'h3FFFF);

    // R10: host request and retention request together
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00000; ret_req = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; ret_req = 1'b0;
    check(!ret_active && !sram_ce_n, "R10", "access wins over retention",
          int'({ret_active, sram_ce_n}), 0);
    while (!rsp_valid) @(negedge clk);
    check(rsp_rdata == 1'b1, "R10", "colliding read data", int'(rsp_rdata), 1);

    // R8: retention pulse during a busy write is dropped
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00123; req_wdata = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    ret_req = 1'b1;
    @(posedge clk); @(negedge clk);
    ret_req = 1'b0;
    shadow[32'h123] = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(!ret_active, "R8", "busy-time retention pulse dropped", int'(ret_active), 0);

    // R8/R9: retention entry, blocked requests, recovery
    ret_req = 1'b1;
    @(posedge clk); @(negedge clk);
    ret_req = 1'b0;
    check(ret_active && sram_ce_n, "R8", "retention active and deselected",
          int'({ret_active, sram_ce_n}), 3);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00123; req_wdata = 1'b0;
    bad = 0;
    repeat (6) begin
      @(posedge clk); @(negedge clk);
      if (req_ready || !sram_ce_n || !ret_active) bad = 1;
    end
    req_valid = 1'b0;
    check(!bad, "R9", "requests refused during retention", int'(bad), 0);
    ret_exit = 1'b1;
    @(posedge clk); @(negedge clk);
    ret_exit = 1'b0;
    check(!ret_active, "R9", "ret_active clears on exit", int'(ret_active), 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00123; req_wdata = 1'b0;
    lat = 1;
    bad = 0;
    while (!req_ready && lat < 100) begin
      if (!sram_ce_n) bad = 1;
      @(posedge clk); @(negedge clk); lat++;
    end
    req_valid = 1'b0;
    check(lat == rc + 1, "R9", "recovery edges", lat, rc + 1);
    check(!bad, "R6", "no access during recovery", int'(bad), 0);
    do_read(18'h00123);

    // Random mix over a small pool plus fully random addresses
    for (int i = 0; i < 8; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 80; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 4 == 0) ? AW'($urandom) : pool[$urandom % 8];
      if ($urandom % 2 == 0) do_write(a, 1'($urandom));
      else do_read(a);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule